// File: doc/BRIEF.md
# Multiprocessor Serial Receiver with Mute Wake-Up

This block is an asynchronous serial receiver for multi-drop links. Each frame has one start bit, eight or nine data bits sent least significant bit first, and one stop bit. The line is sampled on a 16x oversampling tick supplied from outside. A received word goes to the consumer through a valid/ready output. A separate ninth-bit output carries the extra bit in nine-bit mode.

For multiprocessor use, software can put the receiver into mute. While muted, every word is discarded and the status flags do not change. Hardware leaves mute by itself on one of two wake-up events, selected by a control pin:

- **Idle line:** the line stays high for one whole frame time.
- **Address mark:** a word arrives whose most significant received bit is 1. That word is delivered as ordinary data.

**Back-pressure rules:**

- `rd_valid` rises with a new word and stays high, with `rd_data` and `rd_bit9` unchanged, until a cycle in which `rd_ready` is also high.
- The receiver cannot stall the line. If a word completes while an earlier word is still waiting, the new word is dropped and the overrun flag is raised.
- If `rd_ready` accepts the old word in the same cycle that a new word completes, the new word is loaded and no overrun occurs.

Top module: `mpc_rx`

## Requirements
- R1: A frame is a low start bit, then 8 data bits least significant bit first, then a stop bit. Each bit lasts 16 ticks. The data byte appears on `rd_data` with `rd_valid` high once the middle of the stop bit has been sampled.
- R2: With `cfg_nine` = 1, a frame carries 9 data bits. Data bits 0..7 go to `rd_data` and data bit 8 goes to `rd_bit9`.
- R3: With `cfg_nine` = 0, `rd_bit9` of a delivered word reads 0.
- R4: A start bit is accepted only if the line is still low 8 ticks after the falling edge was seen. A shorter low pulse produces no word.
- R5: While `rx_en` = 0, no frame is received and `rd_valid` does not rise.
- R6: Mute is controlled as follows:
  - `mute_set` sets the mute state and `mute_clr` clears it; `mute_set` wins if both are high.
  - The mute state is visible on `mute_o`.
  - While muted, words are discarded, and the valid, overrun and idle flags are not updated.
- R7: `idle_flag` sets when the line has stayed high for one frame time after at least one word has been taken while unmuted, and the receiver is not muted at that moment. A frame time is 160 ticks in 8-bit mode and 176 ticks in 9-bit mode. `ack_flags` clears it.
- R8: While `rd_valid` is high and `rd_ready` is low, `rd_valid`, `rd_data` and `rd_bit9` hold. A cycle with both high clears `rd_valid`.
- R9: If a word completes while `rd_valid` is high and not being accepted, `ovr_flag` sets and the stored word is kept. `ack_flags` clears `ovr_flag` and leaves `rd_valid` as it is.
- R10: `irq` is high when either of these holds:
  - `rx_ie` is set and `rd_valid` or `ovr_flag` is high;
  - `idle_ie` is set and `idle_flag` is high.
- R11: With `cfg_wake_addr` = 1, a muted word whose last data bit is 1 clears mute and is delivered. The last data bit is bit 7 in 8-bit mode and bit 8 in 9-bit mode. A muted word with that bit 0 is discarded.
- R12: With `cfg_wake_addr` = 0, mute clears after a full frame time of continuous high level that follows the most recent low on the line. This wake event does not set `idle_flag`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_line | input | 1 | Serial input, idle high |
| tick16 | input | 1 | One-cycle pulse at 16 times the bit rate |
| rx_en | input | 1 | Receiver enable |
| cfg_nine | input | 1 | 1: nine data bits per frame, 0: eight |
| cfg_wake_addr | input | 1 | Wake method, 1: address mark, 0: idle line |
| mute_set | input | 1 | Pulse that enters mute |
| mute_clr | input | 1 | Pulse that leaves mute |
| rx_ie | input | 1 | Interrupt enable for data-ready and overrun |
| idle_ie | input | 1 | Interrupt enable for idle |
| ack_flags | input | 1 | Pulse that clears the overrun and idle flags |
| rd_ready | input | 1 | Consumer accepts the held word |
| rd_valid | output | 1 | A received word is held |
| rd_data | output | 8 | Received data bits 0..7 |
| rd_bit9 | output | 1 | Ninth received bit |
| ovr_flag | output | 1 | Overrun flag |
| idle_flag | output | 1 | Idle-line flag |
| mute_o | output | 1 | Mute state |
| irq | output | 1 | Combined interrupt |

## Verification
The bound checker checks these properties on every cycle:

- no word reaches the output while mute persists;
- held data stays stable under back-pressure;
- overrun rises only over a pending word;
- a disabled receiver delivers nothing;
- 8-bit mode never delivers a ninth bit;
- the idle flag never rises out of mute;
- the interrupt follows its enabled sources.

Only the bench scenarios can show the remaining behaviour:

- bit order and the value of each received word;
- rejection of a glitch start bit;
- the frame-time length of the idle and idle-wake windows;
- the choice between an address-marked word and a plain word while muted.

// File: rtl/mpc_rx_pkg.sv
package mpc_rx_pkg;

  typedef enum logic [1:0] {
    FR_IDLE,
    FR_START,
    FR_DATA,
    FR_STOP
  } fr_state_e;

endpackage

// File: rtl/mpc_rx_frame.sv
module mpc_rx_frame
  import mpc_rx_pkg::*;
#(
  parameter int OVS    = 16,
  parameter int WORD_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              tick,
  input  logic              nine,
  input  logic              rx_in,
  output logic              rx_s,
  output logic              busy,
  output logic              done,
  output logic [WORD_W-1:0] word
);

  localparam int CW = $clog2(OVS);
  localparam int BW = $clog2(WORD_W + 1);
  localparam logic [CW-1:0] MID  = CW'(OVS / 2 - 1);
  localparam logic [CW-1:0] LAST = CW'(OVS - 1);

  logic [1:0]    sync_q;
  fr_state_e     st;
  logic [CW-1:0] cnt;
  logic [BW-1:0] idx;
  logic [BW-1:0] idx_last;

  // two-flop synchroniser, idle level high
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b11;
    else        sync_q <= {sync_q[0], rx_in};
  end

  assign rx_s     = sync_q[1];
  assign busy     = (st != FR_IDLE);
  assign idx_last = nine ? BW'(WORD_W - 1) : BW'(WORD_W - 2);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= FR_IDLE;
      cnt  <= '0;
      idx  <= '0;
      done <= 1'b0;
      word <= '0;
    end else begin
      done <= 1'b0;
      if (!en) begin
        st  <= FR_IDLE;
        cnt <= '0;
      end else if (tick) begin
        unique case (st)
          FR_IDLE: begin
            if (!rx_s) begin
              st  <= FR_START;
              cnt <= '0;
            end
          end
          FR_START: begin
            if (cnt == MID) begin
              cnt  <= '0;
              idx  <= '0;
              word <= '0;
              st   <= rx_s ? FR_IDLE : FR_DATA;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          FR_DATA: begin
            if (cnt == LAST) begin
              cnt       <= '0;
              word[idx] <= rx_s;
              if (idx == idx_last) st <= FR_STOP;
              else                 idx <= idx + 1'b1;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          FR_STOP: begin
            if (cnt == LAST) begin
              cnt  <= '0;
              st   <= FR_IDLE;
              done <= 1'b1;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          default: st <= FR_IDLE;
        endcase
      end
    end
  end

endmodule

// File: rtl/mpc_rx_idle.sv
module mpc_rx_idle #(
  parameter int OVS    = 16,
  parameter int WORD_W = 9
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic tick,
  input  logic nine,
  input  logic rx_s,
  input  logic busy,
  output logic evt
);

  localparam int FMAX = (WORD_W + 2) * OVS;
  localparam int FMIN = (WORD_W + 1) * OVS;
  localparam int IW   = $clog2(FMAX + 1);

  logic [IW-1:0] cnt;
  logic [IW-1:0] limit;

  assign limit = nine ? IW'(FMAX) : IW'(FMIN);

  // counts high ticks outside a frame, saturates, fires once per run
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      evt <= 1'b0;
    end else begin
      evt <= 1'b0;
      if (!en || busy || !rx_s) begin
        cnt <= '0;
      end else if (tick && (cnt < limit)) begin
        cnt <= cnt + 1'b1;
        evt <= (cnt + 1'b1 == limit);
      end
    end
  end

endmodule

// File: rtl/mpc_rx_ctl.sv
module mpc_rx_ctl #(
  parameter int DATA_W = 8,
  localparam int WORD_W = DATA_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              done,
  input  logic [WORD_W-1:0] word,
  input  logic              nine,
  input  logic              wake_addr,
  input  logic              idle_evt,
  input  logic              mute_set,
  input  logic              mute_clr,
  input  logic              rd_ready,
  input  logic              ack_flags,
  output logic              mute,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_bit9,
  output logic              ovr,
  output logic              idle_flag
);

  logic msb, hit_addr, hit_idle, take, free, armed;

  assign msb      = nine ? word[WORD_W-1] : word[WORD_W-2];
  assign hit_addr = done && mute && wake_addr && msb && !mute_set;
  assign hit_idle = idle_evt && mute && !wake_addr && !mute_set;
  assign take     = done && (!mute || hit_addr);
  assign free     = rd_valid && rd_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mute      <= 1'b0;
      rd_valid  <= 1'b0;
      rd_data   <= '0;
      rd_bit9   <= 1'b0;
      ovr       <= 1'b0;
      idle_flag <= 1'b0;
      armed     <= 1'b0;
    end else begin
      if (mute_set)                              mute <= 1'b1;
      else if (mute_clr || hit_addr || hit_idle) mute <= 1'b0;

      if (take && (!rd_valid || free)) begin
        rd_valid <= 1'b1;
        rd_data  <= word[DATA_W-1:0];
        rd_bit9  <= nine & word[DATA_W];
      end else if (free) begin
        rd_valid <= 1'b0;
      end

      if (take && rd_valid && !free) ovr <= 1'b1;
      else if (ack_flags)            ovr <= 1'b0;

      if (idle_evt && !mute && armed) begin
        idle_flag <= 1'b1;
        armed     <= 1'b0;
      end else begin
        if (ack_flags) idle_flag <= 1'b0;
        if (take)      armed     <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/mpc_rx.sv
module mpc_rx #(
  parameter int OVS    = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_line,
  input  logic              tick16,
  input  logic              rx_en,
  input  logic              cfg_nine,
  input  logic              cfg_wake_addr,
  input  logic              mute_set,
  input  logic              mute_clr,
  input  logic              rx_ie,
  input  logic              idle_ie,
  input  logic              ack_flags,
  input  logic              rd_ready,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_bit9,
  output logic              ovr_flag,
  output logic              idle_flag,
  output logic              mute_o,
  output logic              irq
);

  localparam int WORD_W = DATA_W + 1;

  logic              rx_s, busy, done, idle_evt;
  logic [WORD_W-1:0] word;

  mpc_rx_frame #(.OVS(OVS), .WORD_W(WORD_W)) u_frame (
    .clk(clk), .rst_n(rst_n), .en(rx_en), .tick(tick16), .nine(cfg_nine),
    .rx_in(rx_line), .rx_s(rx_s), .busy(busy), .done(done), .word(word)
  );

  mpc_rx_idle #(.OVS(OVS), .WORD_W(WORD_W)) u_idle (
    .clk(clk), .rst_n(rst_n), .en(rx_en), .tick(tick16), .nine(cfg_nine),
    .rx_s(rx_s), .busy(busy), .evt(idle_evt)
  );

  mpc_rx_ctl #(.DATA_W(DATA_W)) u_ctl (
    .clk(clk), .rst_n(rst_n), .done(done), .word(word), .nine(cfg_nine),
    .wake_addr(cfg_wake_addr), .idle_evt(idle_evt), .mute_set(mute_set),
    .mute_clr(mute_clr), .rd_ready(rd_ready), .ack_flags(ack_flags),
    .mute(mute_o), .rd_valid(rd_valid), .rd_data(rd_data), .rd_bit9(rd_bit9),
    .ovr(ovr_flag), .idle_flag(idle_flag)
  );

  assign irq = (rx_ie && (rd_valid || ovr_flag)) || (idle_ie && idle_flag);

endmodule

// File: rtl/mpc_rx_chk.sv
module mpc_rx_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rx_en,
  input logic              cfg_nine,
  input logic              rx_ie,
  input logic              rd_ready,
  input logic              rd_valid,
  input logic [DATA_W-1:0] rd_data,
  input logic              rd_bit9,
  input logic              ovr_flag,
  input logic              idle_flag,
  input logic              mute_o,
  input logic              irq
);

  p_mute_blocks_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mute_o && $past(mute_o) |-> !$rose(rd_valid));

  p_hold_data_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && !rd_ready |=> rd_valid && $stable(rd_data) && $stable(rd_bit9));

  p_ovr_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovr_flag) |-> $past(rd_valid));

  p_disabled_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rx_en) |-> !$rose(rd_valid));

  p_no_bit9_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_valid) && !$past(cfg_nine) |-> !rd_bit9);

  p_idle_unmuted_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(idle_flag) |-> !$past(mute_o));

  p_irq_rx_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ie && (rd_valid || ovr_flag) |-> irq);

endmodule

bind mpc_rx mpc_rx_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .cfg_nine(cfg_nine), .rx_ie(rx_ie),
  .rd_ready(rd_ready), .rd_valid(rd_valid), .rd_data(rd_data),
  .rd_bit9(rd_bit9), .ovr_flag(ovr_flag), .idle_flag(idle_flag),
  .mute_o(mute_o), .irq(irq)
);

// File: tb/mpc_rx_tb_top.sv
`timescale 1ns/1ps
module mpc_rx_tb_top;

  localparam int BITC = 64;   // 16 ticks x 4 clocks
  localparam int NV   = 5;
  // {nine, word[8:0], exp_data[7:0], exp_bit9}
  localparam logic [18:0] VEC [NV] = '{
    {1'b0, 9'h0A5, 8'hA5, 1'b0},
    {1'b0, 9'h13C, 8'h3C, 1'b0},
    {1'b1, 9'h1C3, 8'hC3, 1'b1},
    {1'b1, 9'h05A, 8'h5A, 1'b0},
    {1'b0, 9'h001, 8'h01, 1'b0}
  };

  logic clk = 1'b0, rst_n = 1'b0, rx_line = 1'b1, tick16 = 1'b0;
  logic rx_en = 1'b1, cfg_nine = 1'b0, cfg_wake_addr = 1'b0;
  logic mute_set = 1'b0, mute_clr = 1'b0, rx_ie = 1'b0, idle_ie = 1'b0;
  logic ack_flags = 1'b0, rd_ready = 1'b0;
  logic rd_valid, rd_bit9, ovr_flag, idle_flag, mute_o, irq;
  logic [7:0] rd_data;
  logic [1:0] tdiv = 2'd0;
  int n_chk = 0, n_err = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  always @(negedge clk) begin
    tdiv   <= tdiv + 2'd1;
    tick16 <= (tdiv == 2'd3);
  end

  mpc_rx dut_i (
    .clk(clk), .rst_n(rst_n), .rx_line(rx_line), .tick16(tick16),
    .rx_en(rx_en), .cfg_nine(cfg_nine), .cfg_wake_addr(cfg_wake_addr),
    .mute_set(mute_set), .mute_clr(mute_clr), .rx_ie(rx_ie),
    .idle_ie(idle_ie), .ack_flags(ack_flags), .rd_ready(rd_ready),
    .rd_valid(rd_valid), .rd_data(rd_data), .rd_bit9(rd_bit9),
    .ovr_flag(ovr_flag), .idle_flag(idle_flag), .mute_o(mute_o), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send(input logic nine, input logic [8:0] w);
    rx_line = 1'b0; wait_clk(BITC);
    for (int i = 0; i < (nine ? 9 : 8); i++) begin
      rx_line = w[i]; wait_clk(BITC);
    end
    rx_line = 1'b1; wait_clk(BITC);
    wait_clk(4);
  endtask

  task automatic pulse_ready();
    rd_ready = 1'b1; wait_clk(1); rd_ready = 1'b0; wait_clk(1);
  endtask

  task automatic pulse_ack();
    ack_flags = 1'b1; wait_clk(1); ack_flags = 1'b0; wait_clk(1);
  endtask

  task automatic pulse_mute();
    mute_set = 1'b1; wait_clk(1); mute_set = 1'b0; wait_clk(1);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  endtask

  initial begin
    wait_clk(150000);
    n_chk++; n_err++;
    $display("FAIL watchdog actual=running expected=done");
    summary();
  end

  initial begin
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(2);
    chk("reset R8 rd_valid", rd_valid, 0);
    chk("reset R9 ovr", ovr_flag, 0);
    chk("reset R7 idle", idle_flag, 0);
    chk("reset R6 mute", mute_o, 0);
    chk("reset R10 irq", irq, 0);

    // R1 R2 R3 R8: vector walk
    for (int v = 0; v < NV; v++) begin
      cfg_nine = VEC[v][18];
      send(VEC[v][18], VEC[v][17:9]);
      wait_clk(20);
      chk("R8 valid held", rd_valid, 1);
      chk("R1 data", rd_data, VEC[v][8:1]);
      chk("R2 R3 bit9", rd_bit9, VEC[v][0]);
      chk("R10 masked irq", irq, 0);
      pulse_ready();
      chk("R8 handshake clears", rd_valid, 0);
    end

    // R7 idle flag after a frame time of high line
    cfg_nine = 1'b0; idle_ie = 1'b1;
    wait_clk(300);
    chk("R7 idle not yet", idle_flag, 0);
    wait_clk(400);
    chk("R7 idle set", idle_flag, 1);
    chk("R10 idle irq", irq, 1);
    pulse_ack();
    chk("R7 idle ack", idle_flag, 0);
    chk("R10 irq drops", irq, 0);
    idle_ie = 1'b0;

    // R9 overrun
    rx_ie = 1'b1;
    send(1'b0, 9'h011);
    chk("R10 rx irq", irq, 1);
    send(1'b0, 9'h022);
    chk("R9 ovr set", ovr_flag, 1);
    chk("R9 old data kept", rd_data, 8'h11);
    pulse_ack();
    chk("R9 ovr ack", ovr_flag, 0);
    chk("R9 valid survives ack", rd_valid, 1);
    pulse_ready();
    chk("R10 irq clear", irq, 0);
    rx_ie = 1'b0;

    // R6 R11 address-mark wake, 8-bit
    cfg_wake_addr = 1'b1;
    pulse_mute();
    chk("R6 mute set", mute_o, 1);
    send(1'b0, 9'h045);
    chk("R6 muted word dropped", rd_valid, 0);
    chk("R11 still muted", mute_o, 1);
    send(1'b0, 9'h085);
    chk("R11 wake clears mute", mute_o, 0);
    chk("R11 wake word valid", rd_valid, 1);
    chk("R11 wake word data", rd_data, 8'h85);
    pulse_ready();

    // R11 address-mark wake, 9-bit
    cfg_nine = 1'b1;
    pulse_mute();
    send(1'b1, 9'h0FF);
    chk("R11 9bit bit7 no wake", mute_o, 1);
    chk("R6 9bit drop", rd_valid, 0);
    send(1'b1, 9'h101);
    chk("R11 9bit wake", mute_o, 0);
    chk("R11 9bit data", rd_data, 8'h01);
    chk("R2 9bit mark", rd_bit9, 1);
    pulse_ready();
    wait_clk(800);
    pulse_ack();

    // R12 idle-line wake
    cfg_nine = 1'b0; cfg_wake_addr = 1'b0;
    pulse_mute();
    wait_clk(800);
    chk("R12 saturated idle no wake", mute_o, 1);
    send(1'b0, 9'h033);
    chk("R6 idle-mode drop", rd_valid, 0);
    wait_clk(300);
    chk("R12 early", mute_o, 1);
    wait_clk(400);
    chk("R12 woke", mute_o, 0);
    chk("R12 no idle flag", idle_flag, 0);
    chk("R6 no ovr while muted", ovr_flag, 0);

    // R6 software clear
    pulse_mute();
    mute_clr = 1'b1; wait_clk(1); mute_clr = 1'b0; wait_clk(1);
    chk("R6 sw clear", mute_o, 0);

    // R5 disabled receiver
    rx_en = 1'b0;
    send(1'b0, 9'h077);
    chk("R5 disabled no word", rd_valid, 0);
    rx_en = 1'b1;
    wait_clk(BITC);

    // R4 glitch start
    rx_line = 1'b0; wait_clk(12); rx_line = 1'b1;
    wait_clk(BITC * 11);
    chk("R4 glitch ignored", rd_valid, 0);
    send(1'b0, 9'h0C6);
    chk("R4 later frame ok", rd_data, 8'hC6);
    chk("R4 later valid", rd_valid, 1);
    pulse_ready();

    summary();
  end

endmodule